// File: doc/BRIEF.md
# Clock Multiplier Configuration Register with Lock Timer

This block is a single 32-bit configuration register for one clock multiplier. It sits on a bus-clock write port. It stores four fields: an input divider, a multiplier, a two-bit output-range code and a six-bit lock-wait count. From these fields it produces registered control outputs for an analog PLL that lives outside the block: an enable, a divider-bypass flag, the divide ratio and the multiply ratio. It also drives the range code out unchanged.

Each write starts a lock wait that is counted on a separate slow clock. The write event crosses into the slow domain as a toggle. The slow side counts the programmed number of cycles and raises a lock flag. That flag returns to the bus clock through a two-flop synchronizer. A small digital divider, clocked by the bus clock, counts pulses of an input-clock enable and produces the divided enable that the divider field selects. A write with the mandatory marker bit clear sets a sticky error flag.

Top module: `pll_cfg_reg`

## Requirements
- R1: After reset and after every write, `rd_data` shows the divider in bits 7:0, the lock count in bits 13:8, the range code in bits 15:14 and the multiplier in bits 26:16. Bit 29 reads 1 and every other bit reads 0. The reset value is 0x2000_0000.
- R2: In the cycle after any write, `locked` is 0, whatever its earlier value.
- R3: With a lock count N and a nonzero multiplier, `locked` stays 0 until at least N+4 slow-clock rising edges have passed since the write, and is 1 once N+8 have passed with no further write.
- R4: A multiplier field of 0 gives `pll_en` = 0 and `mul_ratio` = 0, and `locked` never rises.
- R5: A nonzero multiplier field M gives `pll_en` = 1 and `mul_ratio` = M+1.
- R6: A divider field of 0 keeps `div_tick` at 0.
- R7: A divider field of 1 sets `div_bypass`, and `div_tick` then equals `in_tick` delayed by one bus cycle.
- R8: A divider field D of 2 or more gives `div_ratio` = D. Counting `in_tick` pulses from the write, `div_tick` pulses once, one cycle after every D-th pulse.
- R9: A write with bit 29 of `wr_data` at 0 sets `cfg_err`, which then stays 1 until reset.
- R10: `out_range` equals bits 15:14 of the last written word and has no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Slow clock that times the lock wait |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| in_tick | input | 1 | Enable marking each input-clock period |
| div_tick | output | 1 | Divided input-clock enable |
| pll_en | output | 1 | Multiplier enable |
| div_bypass | output | 1 | Divider bypass selected |
| div_ratio | output | 8 | Divider field value |
| mul_ratio | output | 12 | Multiply ratio (multiplier field + 1), 0 when disabled |
| out_range | output | 2 | Output-range code for the analog side |
| locked | output | 1 | Lock flag, bus domain |
| cfg_err | output | 1 | Sticky marker-bit error |

## Verification
The assertions assume that resets are applied long enough to cover at least two slow-clock edges, and that `wr_en` is low while `rst` is high. They also assume that successive writes are far enough apart for the slow side to see each toggle, which means at least three slow-clock periods. The stimulus respects these assumptions: every write waits out its full lock window, which is always longer than three slow cycles. `in_tick` is held low in each write cycle so that the restart of the divider is unambiguous. All other cycles draw it at random.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int DIV_W   = 8;
  localparam int CNT_W   = 6;
  localparam int RNG_W   = 2;
  localparam int MUL_W   = 11;
  localparam int KEY_BIT = 29;

  // Packed from MSB to LSB: multiplier 26:16, range 15:14, count 13:8, divider 7:0
  typedef struct packed {
    logic [MUL_W-1:0] mul;
    logic [RNG_W-1:0] rng;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div;
  } pll_cfg_t;

  localparam int CFG_W   = $bits(pll_cfg_t);
  localparam int RATIO_W = MUL_W + 1;
endpackage

// File: rtl/pll_cfg_sync.sv
module pll_cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= '0;
      else if (i == 0) stage_q[i] <= d;
      else stage_q[i] <= stage_q[(i > 0) ? i-1 : 0];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock #(
  parameter int CNT_W  = 6,
  parameter int STAGES = 2
) (
  input  logic             slow_clk,
  input  logic             slow_rst,
  input  logic             wr_tgl,
  input  logic [CNT_W-1:0] cnt_lim,
  input  logic             pll_on,
  output logic             lock_s,
  output logic             ack_s
);
  logic             tgl_sync;
  logic             tgl_d;
  logic             restart;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  pll_cfg_sync #(.WIDTH(1), .STAGES(STAGES)) u_tgl_sync (
    .clk (slow_clk),
    .rst (slow_rst),
    .d   (wr_tgl),
    .q   (tgl_sync)
  );

  assign restart = tgl_sync ^ tgl_d;

  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      tgl_d  <= 1'b0;
      ack_s  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      lock_s <= 1'b0;
    end else begin
      tgl_d <= tgl_sync;
      // acknowledge one slow cycle after the clear, so lock is already low
      ack_s <= tgl_d;
      if (restart) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        lock_s <= 1'b0;
      end else if (run_q) begin
        if (cnt_q == cnt_lim) begin
          run_q  <= 1'b0;
          lock_s <= pll_on;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_cfg_refdiv.sv
module pll_cfg_refdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             in_tick,
  input  logic [DIV_W-1:0] div,
  output logic             div_tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q    <= '0;
      div_tick <= 1'b0;
    end else if (div == '0) begin
      cnt_q    <= '0;
      div_tick <= 1'b0;
    end else if (div == ONE) begin
      cnt_q    <= '0;
      div_tick <= in_tick;
    end else if (in_tick) begin
      if (cnt_q == div - ONE) begin
        cnt_q    <= '0;
        div_tick <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + ONE;
        div_tick <= 1'b0;
      end
    end else begin
      div_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_cfg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_clk,
  input  logic               slow_rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               in_tick,
  output logic               div_tick,
  output logic               pll_en,
  output logic               div_bypass,
  output logic [DIV_W-1:0]   div_ratio,
  output logic [RATIO_W-1:0] mul_ratio,
  output logic [RNG_W-1:0]   out_range,
  output logic               locked,
  output logic               cfg_err
);
  pll_cfg_t cfg_q;
  pll_cfg_t cfg_in;
  logic     wr_tgl;
  logic     lock_s;
  logic     ack_s;
  logic     lock_b;
  logic     ack_b;
  logic     pending;

  assign cfg_in = pll_cfg_t'(wr_data[CFG_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      wr_tgl     <= 1'b0;
      cfg_err    <= 1'b0;
      pll_en     <= 1'b0;
      div_bypass <= 1'b0;
      div_ratio  <= '0;
      mul_ratio  <= '0;
      out_range  <= '0;
    end else if (wr_en) begin
      cfg_q      <= cfg_in;
      wr_tgl     <= ~wr_tgl;
      pll_en     <= |cfg_in.mul;
      div_bypass <= (cfg_in.div == DIV_W'(1));
      div_ratio  <= cfg_in.div;
      mul_ratio  <= (|cfg_in.mul) ? ({1'b0, cfg_in.mul} + RATIO_W'(1)) : '0;
      out_range  <= cfg_in.rng;
      if (!wr_data[KEY_BIT]) cfg_err <= 1'b1;
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[CFG_W-1:0] = cfg_q;
    rd_data[KEY_BIT]   = 1'b1;
  end

  pll_cfg_lock #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_lock (
    .slow_clk (slow_clk),
    .slow_rst (slow_rst),
    .wr_tgl   (wr_tgl),
    .cnt_lim  (cfg_q.cnt),
    .pll_on   (pll_en),
    .lock_s   (lock_s),
    .ack_s    (ack_s)
  );

  pll_cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk (clk),
    .rst (rst),
    .d   ({lock_s, ack_s}),
    .q   ({lock_b, ack_b})
  );

  assign pending = ack_b ^ wr_tgl;

  always_ff @(posedge clk) begin
    if (rst || wr_en) locked <= 1'b0;
    else              locked <= lock_b & ~pending & pll_en;
  end

  pll_cfg_refdiv #(.DIV_W(DIV_W)) u_refdiv (
    .clk      (clk),
    .rst      (rst),
    .restart  (wr_en),
    .in_tick  (in_tick),
    .div      (cfg_q.div),
    .div_tick (div_tick)
  );
endmodule

// File: rtl/pll_cfg_reg_chk.sv
module pll_cfg_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        in_tick,
  input logic        div_tick,
  input logic        pll_en,
  input logic        div_bypass,
  input logic [11:0] mul_ratio,
  input logic [1:0]  out_range,
  input logic        locked,
  input logic        cfg_err
);
  AST_KEY_BIT_SET: assert property (@(posedge clk) disable iff (rst)
    rd_data[29]); // R1
  AST_WRITE_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !locked); // R2
  AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    !pll_en |-> !locked); // R4
  AST_OFF_ON_ZERO_MUL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[26:16] == 11'd0) |=> (!pll_en && mul_ratio == 12'd0)); // R4
  AST_RATIO_MATCH: assert property (@(posedge clk) disable iff (rst)
    pll_en |-> (mul_ratio == {1'b0, rd_data[26:16]} + 12'd1)); // R5
  AST_DIV_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rd_data[7:0] == 8'd0) |-> !div_tick); // R6
  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(div_bypass && !wr_en) |-> (div_tick == $past(in_tick))); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[29]) |=> cfg_err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R9
  AST_RANGE_PASS: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !rst) |-> (out_range == $past(wr_data[15:14]))); // R10
endmodule

bind pll_cfg_reg pll_cfg_reg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .in_tick    (in_tick),
  .div_tick   (div_tick),
  .pll_en     (pll_en),
  .div_bypass (div_bypass),
  .mul_ratio  (mul_ratio),
  .out_range  (out_range),
  .locked     (locked),
  .cfg_err    (cfg_err)
);

// File: tb/pll_cfg_reg_bench.sv
`timescale 1ns/1ps
module pll_cfg_reg_bench;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        in_tick = 1'b0;
  logic        div_tick;
  logic        pll_en;
  logic        div_bypass;
  logic [7:0]  div_ratio;
  logic [11:0] mul_ratio;
  logic [1:0]  out_range;
  logic        locked;
  logic        cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int scnt = 0;
  bit err_exp = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #32 slow_clk = ~slow_clk;
  end
  always @(posedge slow_clk) scnt <= scnt + 1;

  pll_cfg_reg u_pll_cfg_reg (
    .clk (clk), .rst (rst), .slow_clk (slow_clk), .slow_rst (slow_rst),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data),
    .in_tick (in_tick), .div_tick (div_tick), .pll_en (pll_en),
    .div_bypass (div_bypass), .div_ratio (div_ratio), .mul_ratio (mul_ratio),
    .out_range (out_range), .locked (locked), .cfg_err (cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [31:0] w);
    return (w & 32'h07FF_FFFF) | 32'h2000_0000;
  endfunction

  function automatic logic [11:0] exp_ratio(input logic [31:0] w);
    return (w[26:16] == 11'd0) ? 12'd0 : {1'b0, w[26:16]} + 12'd1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slow_rst = 1'b1; wr_en = 1'b0; in_tick = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b0; slow_rst = 1'b0;
    err_exp = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] w);
    int s0;
    int n;
    int dcnt;
    int early;
    int mism;
    bit exp_tick;
    logic [7:0] dv;
    @(negedge clk);
    wr_en = 1'b1; wr_data = w; in_tick = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    s0 = scnt;
    n = int'(w[13:8]);
    dv = w[7:0];
    if (!w[29]) err_exp = 1'b1;
    chk("R1 readback", rd_data, exp_rd(w));
    chk("R2 lock cleared", {31'd0, locked}, 32'd0);
    chk("R4/R5 enable", {31'd0, pll_en}, {31'd0, w[26:16] != 11'd0});
    chk("R5 ratio", {20'd0, mul_ratio}, {20'd0, exp_ratio(w)});
    chk("R8 div ratio", {24'd0, div_ratio}, {24'd0, dv});
    chk("R7 bypass flag", {31'd0, div_bypass}, {31'd0, dv == 8'd1});
    chk("R10 range", {30'd0, out_range}, {30'd0, w[15:14]});
    chk("R9 err flag", {31'd0, cfg_err}, {31'd0, err_exp});
    exp_tick = 1'b0; dcnt = 0; early = 0; mism = 0;
    while (scnt - s0 < n + 8) begin
      if (div_tick !== exp_tick) mism++;
      if (locked && ((scnt - s0 < n + 4) || w[26:16] == 11'd0)) early++;
      in_tick = ($urandom % 3) != 0;
      if (dv == 8'd0) exp_tick = 1'b0;
      else if (dv == 8'd1) exp_tick = in_tick;
      else if (in_tick) begin
        if (dcnt == int'(dv) - 1) begin dcnt = 0; exp_tick = 1'b1; end
        else begin dcnt++; exp_tick = 1'b0; end
      end else exp_tick = 1'b0;
      @(negedge clk);
    end
    in_tick = 1'b0;
    chk("R3 no early lock", early, 0);
    chk("R3/R4 lock final", {31'd0, locked}, {31'd0, w[26:16] != 11'd0});
    if (dv == 8'd0)      chk("R6 divider off", mism, 0);
    else if (dv == 8'd1) chk("R7 divider bypass", mism, 0);
    else                 chk("R8 divider pulses", mism, 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    do_reset();
    chk("R1 reset value", rd_data, 32'h2000_0000);
    chk("R4 reset enable", {31'd0, pll_en}, 32'd0);
    chk("R2 reset lock", {31'd0, locked}, 32'd0);
    chk("R9 reset err", {31'd0, cfg_err}, 32'd0);
    do_write(32'h2005_0300);
    do_write(32'h20FE_4001);
    do_write(32'h2001_8002);
    do_write(32'h2000_0A07);
    do_write(32'h2010_3FFF);
    do_write(32'hFFFF_FFFF);
    do_write(32'h0003_0203);
    do_write(32'h2000_0005);
    for (int i = 0; i < 30; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[29] = ($urandom % 8) != 0;
      w[13:8] = 6'($urandom % 16);
      case ($urandom % 4)
        0: w[7:0] = 8'd0;
        1: w[7:0] = 8'd1;
        default: w[7:0] = 8'd2 + 8'($urandom % 20);
      endcase
      if (($urandom % 5) == 0) w[26:16] = 11'd0;
      else w[26:16] = 11'd1 + 11'($urandom % 254);
      do_write(w);
    end
    do_reset();
    chk("R9 err cleared by reset", {31'd0, cfg_err}, 32'd0);
    chk("R1 reset value again", rd_data, 32'h2000_0000);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule